// File: doc/BRIEF.md
# NAND Read-Retry Command Sequencer

This block puts a multi-level-cell flash die into a selected read-retry level and fetches the die's retry parameter page from its one-time-programmable area. It sits above a byte-level NAND PHY. It hands that PHY a stream of typed beats, each one a command byte, an address byte, a data-out byte or a data-in request, and each beat waits for a ready/valid handshake. The PHY owns bus timing, the ready/busy wait inside page reads, and the reporting of a failed step.

There are two entry points. A retry-apply request takes a mode number. The block checks the mode against the programmed mode count, enters the die's private parameter-write mode and writes one value into each retry register. It reads those values from a local table that is loaded through a simple write port, and then it issues the apply opcode. An OTP-fetch request runs the unlock sequence, reads the parameter page and streams each returned byte out, then runs the cleanup sequence. After that it waits for an external decoder to say whether the page decoded. If the first page layout fails, the block repeats the whole sequence with the second layout. If the second layout also fails, the request ends in an error.

Top module: `retry_seq`

## Requirements
- R1: A retry-apply request with a valid mode emits command 0x36 as its first beat and command 0x16 as its last beat, then pulses `done` for one cycle. Beat type codes on `busType` are 0 for command, 1 for address, 2 for data-out and 3 for data-in request.
- R2: Between those two commands, each of the NREGS retry registers is written as one address beat carrying the register offset, followed by one data-out beat. The offsets are used in the order 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE, 0xAF.
- R3: For mode m, the data-out value written to register i is table entry m*NREGS+i, and i runs upward from 0. The table is loaded through `tblWe`/`tblAddr`/`tblData`.
- R4: A retry-apply request whose mode is not below `modeCount` is rejected. The block pulses `err` for one cycle and emits no beat.
- R5: An OTP fetch emits the following beats in order: command 0xFF, command 0x36, address 0x38, data-out 0x52, command 0x16, and then commands 0x17, 0x04 and 0x19.
- R6: A page read is framed as command 0x00, two zero column address bytes, three row address bytes least significant first, command 0x30, and then one data-in request per page byte with byte value 0. The PHY's `rdByte` at each data-in handshake appears on `otpByte` with `otpValid` high in the following cycle.
- R7: After the page bytes, cleanup emits command 0xFF, command 0x36, address 0x38, data-out 0x00 and command 0x16. It then emits a dummy read of page 0 with no data-in requests: command 0x00, five zero address bytes and command 0x30.
- R8: After cleanup the block waits for `verdictValid`. If `verdictOk` is set it pulses `done`. If the first layout (page 0x21F, 784 bytes) failed, it reruns the full fetch with the second layout (page 0x200, 528 bytes). If the second layout fails, it pulses `err`.
- R9: If `phyErr` is high at a beat handshake, the sequence aborts. The block pulses `err`, not `done`, and emits no further beat.
- R10: While `busValid` is high and `busReady` is low, the beat type and byte hold steady. Requests that arrive while a sequence is running are ignored.
- R11: During and right after reset, `busValid`, `otpValid`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| applyReq | input | 1 | Start retry-apply with `modeSel` (idle only) |
| modeSel | input | MODE_W | Requested retry mode |
| otpReq | input | 1 | Start OTP parameter fetch (idle only) |
| modeCount | input | MODE_W+1 | Number of valid retry modes |
| tblWe | input | 1 | Table write enable |
| tblAddr | input | TBL_AW | Table write index (mode*NREGS+reg) |
| tblData | input | 8 | Table write value |
| busValid | output | 1 | Beat valid toward the PHY |
| busType | output | 2 | Beat type: 0 cmd, 1 addr, 2 data-out, 3 data-in request |
| busByte | output | 8 | Beat byte |
| busReady | input | 1 | PHY accepts the beat |
| rdByte | input | 8 | Byte returned with a data-in handshake |
| phyErr | input | 1 | PHY reports the handshaked step failed |
| verdictValid | input | 1 | Decoder verdict on the fetched page |
| verdictOk | input | 1 | Page decoded correctly |
| otpValid | output | 1 | Streamed page byte valid |
| otpByte | output | 8 | Streamed page byte |
| done | output | 1 | One-cycle pulse on success |
| err | output | 1 | One-cycle pulse on rejection or failure |

## Verification
A corrupted step counter or phase flag in this block shows up at the PHY port at the first wrong handshake. Examples are a missing unlock opcode, a row byte from the wrong layout, or a cleanup key of 0x52 where 0x00 belongs. The full beat stream is therefore compared against an independently built expectation, beat by beat. A wrong table index shows as a data-out mismatch in the first register pair that follows it. A lost handshake hold shows within one stalled cycle as a beat that changes while ready is low. A wrong page length or a missed fallback shows as a beat count mismatch before the verdict, or as a wrong done/err pulse after it.

// File: rtl/retry_seq_pkg.sv
package retry_seq_pkg;

  typedef enum logic [1:0] {
    BT_CMD  = 2'd0,
    BT_ADDR = 2'd1,
    BT_DOUT = 2'd2,
    BT_DIN  = 2'd3
  } beat_e;

  typedef enum logic [3:0] {
    SRC_ZERO,
    SRC_RESET,
    SRC_ENTER,
    SRC_APPLY,
    SRC_U17,
    SRC_U04,
    SRC_U19,
    SRC_RDCMD,
    SRC_RDCONF,
    SRC_REGOFF,
    SRC_REGVAL,
    SRC_OTPREG,
    SRC_OTPKEY,
    SRC_PAGEADDR
  } src_e;

  typedef struct packed {
    src_e src;
    logic latchMode;
    logic clrReg;
    logic incReg;
    logic clrCnt;
    logic incCnt;
    logic setAlt;
    logic clrAlt;
    logic capture;
  } dp_ctl_t;

  localparam logic [7:0] OP_RESET   = 8'hFF;
  localparam logic [7:0] OP_ENTER   = 8'h36;
  localparam logic [7:0] OP_APPLY   = 8'h16;
  localparam logic [7:0] OP_U17     = 8'h17;
  localparam logic [7:0] OP_U04     = 8'h04;
  localparam logic [7:0] OP_U19     = 8'h19;
  localparam logic [7:0] OP_RDCMD   = 8'h00;
  localparam logic [7:0] OP_RDCONF  = 8'h30;
  localparam logic [7:0] OTP_REG    = 8'h38;
  localparam logic [7:0] OTP_KEY    = 8'h52;

  function automatic logic [7:0] retryRegOffset(input logic [2:0] idx);
    case (idx)
      3'd0: retryRegOffset = 8'hCC;
      3'd1: retryRegOffset = 8'hBF;
      3'd2: retryRegOffset = 8'hAA;
      3'd3: retryRegOffset = 8'hAB;
      3'd4: retryRegOffset = 8'hCD;
      3'd5: retryRegOffset = 8'hAD;
      3'd6: retryRegOffset = 8'hAE;
      default: retryRegOffset = 8'hAF;
    endcase
  endfunction

endpackage

// File: rtl/retry_seq_table.sv
module retry_seq_table #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [7:0]    wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  assign rdData = mem[rdAddr];
endmodule

// File: rtl/retry_seq_dp.sv
module retry_seq_dp
  import retry_seq_pkg::*;
#(
  parameter int          MODES = 8,
  parameter int          NREGS = 8,
  parameter int          LEN0  = 784,
  parameter int          LEN1  = 528,
  parameter logic [23:0] PAGE0 = 24'h00021F,
  parameter logic [23:0] PAGE1 = 24'h000200,
  localparam int MODE_W = $clog2(MODES),
  localparam int TBL_AW = $clog2(MODES * NREGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic [MODE_W-1:0] modeSel,
  input  logic [MODE_W:0]   modeCount,
  input  logic              tblWe,
  input  logic [TBL_AW-1:0] tblAddr,
  input  logic [7:0]        tblData,
  input  logic [7:0]        rdByte,
  output logic [7:0]        busByte,
  output logic              modeOk,
  output logic              regLast,
  output logic              addrLast,
  output logic              dataLast,
  output logic              altLayout,
  output logic              otpValid,
  output logic [7:0]        otpByte
);
  localparam int MAXLEN = (LEN0 > LEN1) ? LEN0 : LEN1;
  localparam int CNT_W  = $clog2(MAXLEN + 1);
  localparam int REG_W  = 3;
  localparam logic [CNT_W-1:0] LEN0M1 = CNT_W'(LEN0 - 1);
  localparam logic [CNT_W-1:0] LEN1M1 = CNT_W'(LEN1 - 1);
  localparam logic [REG_W-1:0] REGM1  = REG_W'(NREGS - 1);

  logic [MODE_W-1:0] modeQ;
  logic [REG_W-1:0]  regIdx;
  logic [CNT_W-1:0]  cnt;
  logic [TBL_AW-1:0] rdIdx;
  logic [7:0]        tblQ;
  logic [23:0]       page;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= '0;
      regIdx    <= '0;
      cnt       <= '0;
      altLayout <= 1'b0;
      otpValid  <= 1'b0;
      otpByte   <= 8'h00;
    end else begin
      if (ctl.latchMode) modeQ <= modeSel;
      if (ctl.clrReg) regIdx <= '0;
      else if (ctl.incReg) regIdx <= regIdx + 1'b1;
      if (ctl.clrCnt) cnt <= '0;
      else if (ctl.incCnt) cnt <= cnt + 1'b1;
      if (ctl.setAlt) altLayout <= 1'b1;
      else if (ctl.clrAlt) altLayout <= 1'b0;
      otpValid <= ctl.capture;
      if (ctl.capture) otpByte <= rdByte;
    end
  end

  assign rdIdx = TBL_AW'(int'(modeQ) * NREGS + int'(regIdx));

  retry_seq_table #(.DEPTH(MODES * NREGS)) u_table (
    .clk   (clk),
    .wrEn  (tblWe),
    .wrAddr(tblAddr),
    .wrData(tblData),
    .rdAddr(rdIdx),
    .rdData(tblQ)
  );

  assign modeOk   = ({1'b0, modeSel} < modeCount);
  assign regLast  = (regIdx == REGM1);
  assign addrLast = (cnt == CNT_W'(4));
  assign dataLast = (cnt == (altLayout ? LEN1M1 : LEN0M1));
  assign page     = altLayout ? PAGE1 : PAGE0;

  always_comb begin
    busByte = 8'h00;
    case (ctl.src)
      SRC_RESET:  busByte = OP_RESET;
      SRC_ENTER:  busByte = OP_ENTER;
      SRC_APPLY:  busByte = OP_APPLY;
      SRC_U17:    busByte = OP_U17;
      SRC_U04:    busByte = OP_U04;
      SRC_U19:    busByte = OP_U19;
      SRC_RDCMD:  busByte = OP_RDCMD;
      SRC_RDCONF: busByte = OP_RDCONF;
      SRC_REGOFF: busByte = retryRegOffset(regIdx);
      SRC_REGVAL: busByte = tblQ;
      SRC_OTPREG: busByte = OTP_REG;
      SRC_OTPKEY: busByte = OTP_KEY;
      SRC_PAGEADDR: begin
        if (cnt == CNT_W'(2)) busByte = page[7:0];
        else if (cnt == CNT_W'(3)) busByte = page[15:8];
        else if (cnt == CNT_W'(4)) busByte = page[23:16];
        else busByte = 8'h00;
      end
      default:    busByte = 8'h00;
    endcase
  end
endmodule

// File: rtl/retry_seq_ctrl.sv
module retry_seq_ctrl
  import retry_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    applyReq,
  input  logic    otpReq,
  input  logic    modeOk,
  input  logic    regLast,
  input  logic    addrLast,
  input  logic    dataLast,
  input  logic    altLayout,
  input  logic    busReady,
  input  logic    phyErr,
  input  logic    verdictValid,
  input  logic    verdictOk,
  output logic    busValid,
  output beat_e   busType,
  output dp_ctl_t ctl,
  output logic    done,
  output logic    err
);
  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_ENTER, S_RADDR, S_RDATA, S_APPLY,
    S_U17, S_U04, S_U19, S_PCMD, S_PADDR, S_PCONF, S_PDIN, S_VERDICT
  } state_e;

  state_e state, nxt;
  logic   isApply, nApply;
  logic   isClean, nClean;
  logic   doneN, errN;
  logic   hs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      isApply <= 1'b0;
      isClean <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      state   <= nxt;
      isApply <= nApply;
      isClean <= nClean;
      done    <= doneN;
      err     <= errN;
    end
  end

  assign busValid = (state != S_IDLE) && (state != S_VERDICT);
  assign hs       = busValid && busReady;

  always_comb begin
    case (state)
      S_RADDR, S_PADDR: busType = BT_ADDR;
      S_RDATA:          busType = BT_DOUT;
      S_PDIN:           busType = BT_DIN;
      default:          busType = BT_CMD;
    endcase
  end

  always_comb begin
    nxt    = state;
    nApply = isApply;
    nClean = isClean;
    doneN  = 1'b0;
    errN   = 1'b0;
    ctl    = '0;
    ctl.src = SRC_ZERO;
    case (state)
      S_IDLE: begin
        if (applyReq) begin
          if (modeOk) begin
            ctl.latchMode = 1'b1;
            ctl.clrReg    = 1'b1;
            nApply = 1'b1;
            nClean = 1'b0;
            nxt    = S_ENTER;
          end else begin
            errN = 1'b1;
          end
        end else if (otpReq) begin
          ctl.clrAlt = 1'b1;
          nApply = 1'b0;
          nClean = 1'b0;
          nxt    = S_RST;
        end
      end
      S_RST: begin
        ctl.src = SRC_RESET;
        if (hs) nxt = S_ENTER;
      end
      S_ENTER: begin
        ctl.src = SRC_ENTER;
        if (hs) nxt = S_RADDR;
      end
      S_RADDR: begin
        ctl.src = isApply ? SRC_REGOFF : SRC_OTPREG;
        if (hs) nxt = S_RDATA;
      end
      S_RDATA: begin
        ctl.src = isApply ? SRC_REGVAL : (isClean ? SRC_ZERO : SRC_OTPKEY);
        if (hs) begin
          if (isApply && !regLast) begin
            ctl.incReg = 1'b1;
            nxt = S_RADDR;
          end else begin
            nxt = S_APPLY;
          end
        end
      end
      S_APPLY: begin
        ctl.src = SRC_APPLY;
        if (hs) begin
          if (isApply) begin
            doneN = 1'b1;
            nxt   = S_IDLE;
          end else if (isClean) begin
            ctl.clrCnt = 1'b1;
            nxt = S_PCMD;
          end else begin
            nxt = S_U17;
          end
        end
      end
      S_U17: begin
        ctl.src = SRC_U17;
        if (hs) nxt = S_U04;
      end
      S_U04: begin
        ctl.src = SRC_U04;
        if (hs) nxt = S_U19;
      end
      S_U19: begin
        ctl.src = SRC_U19;
        if (hs) begin
          ctl.clrCnt = 1'b1;
          nxt = S_PCMD;
        end
      end
      S_PCMD: begin
        ctl.src = SRC_RDCMD;
        if (hs) nxt = S_PADDR;
      end
      S_PADDR: begin
        ctl.src = isClean ? SRC_ZERO : SRC_PAGEADDR;
        if (hs) begin
          ctl.incCnt = 1'b1;
          if (addrLast) begin
            ctl.clrCnt = 1'b1;
            nxt = S_PCONF;
          end
        end
      end
      S_PCONF: begin
        ctl.src = SRC_RDCONF;
        if (hs) begin
          if (isClean) begin
            nxt = S_VERDICT;
          end else begin
            ctl.clrCnt = 1'b1;
            nxt = S_PDIN;
          end
        end
      end
      S_PDIN: begin
        ctl.src = SRC_ZERO;
        if (hs) begin
          ctl.capture = 1'b1;
          ctl.incCnt  = 1'b1;
          if (dataLast) begin
            nClean = 1'b1;
            nxt    = S_RST;
          end
        end
      end
      S_VERDICT: begin
        if (verdictValid) begin
          if (verdictOk) begin
            doneN = 1'b1;
            nxt   = S_IDLE;
          end else if (!altLayout) begin
            ctl.setAlt = 1'b1;
            nClean = 1'b0;
            nxt    = S_RST;
          end else begin
            errN = 1'b1;
            nxt  = S_IDLE;
          end
        end
      end
      default: nxt = S_IDLE;
    endcase
    if (hs && phyErr) begin
      nxt         = S_IDLE;
      errN        = 1'b1;
      doneN       = 1'b0;
      ctl.capture = 1'b0;
    end
  end
endmodule

// File: rtl/retry_seq.sv
module retry_seq
  import retry_seq_pkg::*;
#(
  parameter int          MODES = 8,
  parameter int          NREGS = 8,
  parameter int          LEN0  = 784,
  parameter int          LEN1  = 528,
  parameter logic [23:0] PAGE0 = 24'h00021F,
  parameter logic [23:0] PAGE1 = 24'h000200,
  localparam int MODE_W = $clog2(MODES),
  localparam int TBL_AW = $clog2(MODES * NREGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              applyReq,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              otpReq,
  input  logic [MODE_W:0]   modeCount,
  input  logic              tblWe,
  input  logic [TBL_AW-1:0] tblAddr,
  input  logic [7:0]        tblData,
  output logic              busValid,
  output logic [1:0]        busType,
  output logic [7:0]        busByte,
  input  logic              busReady,
  input  logic [7:0]        rdByte,
  input  logic              phyErr,
  input  logic              verdictValid,
  input  logic              verdictOk,
  output logic              otpValid,
  output logic [7:0]        otpByte,
  output logic              done,
  output logic              err
);
  dp_ctl_t ctl;
  beat_e   beatType;
  logic    modeOk, regLast, addrLast, dataLast, altLayout;

  retry_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .applyReq    (applyReq),
    .otpReq      (otpReq),
    .modeOk      (modeOk),
    .regLast     (regLast),
    .addrLast    (addrLast),
    .dataLast    (dataLast),
    .altLayout   (altLayout),
    .busReady    (busReady),
    .phyErr      (phyErr),
    .verdictValid(verdictValid),
    .verdictOk   (verdictOk),
    .busValid    (busValid),
    .busType     (beatType),
    .ctl         (ctl),
    .done        (done),
    .err         (err)
  );

  retry_seq_dp #(
    .MODES(MODES), .NREGS(NREGS), .LEN0(LEN0), .LEN1(LEN1),
    .PAGE0(PAGE0), .PAGE1(PAGE1)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .modeSel  (modeSel),
    .modeCount(modeCount),
    .tblWe    (tblWe),
    .tblAddr  (tblAddr),
    .tblData  (tblData),
    .rdByte   (rdByte),
    .busByte  (busByte),
    .modeOk   (modeOk),
    .regLast  (regLast),
    .addrLast (addrLast),
    .dataLast (dataLast),
    .altLayout(altLayout),
    .otpValid (otpValid),
    .otpByte  (otpByte)
  );

  assign busType = beatType;
endmodule

// File: rtl/retry_seq_chk.sv
module retry_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busValid,
  input logic       busReady,
  input logic [1:0] busType,
  input logic [7:0] busByte,
  input logic       otpValid,
  input logic       done,
  input logic       err
);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady |=> busValid && $stable(busByte) && $stable(busType));

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !busValid);

  // R8
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  otp_after_din_chk: assert property (@(posedge clk) disable iff (!rstN)
    otpValid |-> $past(busValid && busReady && busType == 2'd3));
endmodule

bind retry_seq retry_seq_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busValid(busValid),
  .busReady(busReady),
  .busType (busType),
  .busByte (busByte),
  .otpValid(otpValid),
  .done    (done),
  .err     (err)
);

// File: tb/retry_seq_tb.sv
`timescale 1ns/1ps
module retry_seq_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic       applyReq, otpReq, tblWe, busReady, phyErr, verdictValid, verdictOk;
  logic [2:0] modeSel;
  logic [3:0] modeCount;
  logic [5:0] tblAddr;
  logic [7:0] tblData, rdByte;
  logic       busValid, otpValid, done, err;
  logic [1:0] busType;
  logic [7:0] busByte, otpByte;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int errAt = -1;
  int doneCnt = 0;
  int errCnt = 0;
  bit readyAlways = 0;
  logic [7:0] tbl [64];
  logic [9:0] gotQ[$];
  logic [9:0] expQ[$];
  logic [7:0] gotStream[$];
  logic [7:0] expStream[$];

  always #2.5 clk = ~clk;

  retry_seq u_dut (
    .clk(clk), .rstN(rstN), .applyReq(applyReq), .modeSel(modeSel),
    .otpReq(otpReq), .modeCount(modeCount), .tblWe(tblWe), .tblAddr(tblAddr),
    .tblData(tblData), .busValid(busValid), .busType(busType), .busByte(busByte),
    .busReady(busReady), .rdByte(rdByte), .phyErr(phyErr),
    .verdictValid(verdictValid), .verdictOk(verdictOk), .otpValid(otpValid),
    .otpByte(otpByte), .done(done), .err(err)
  );

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // PHY model and monitor
  always begin
    @(negedge clk);
    busReady = readyAlways ? 1'b1 : (($urandom % 4) != 0);
    rdByte   = 8'($urandom);
    phyErr   = (errAt >= 0) && (gotQ.size() == errAt);
    #0.5;
    if (rstN && busValid && busReady) begin
      gotQ.push_back({busType, busByte});
      if (busType == 2'd3) expStream.push_back(rdByte);
    end
    if (otpValid) gotStream.push_back(otpByte);
    if (done) doneCnt++;
    if (err) errCnt++;
    cyc++;
    if (cyc == 180000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp<%0d", cyc, 180000);
      summary();
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] offsetOf(int i);
    case (i)
      0: return 8'hCC; 1: return 8'hBF; 2: return 8'hAA; 3: return 8'hAB;
      4: return 8'hCD; 5: return 8'hAD; 6: return 8'hAE; default: return 8'hAF;
    endcase
  endfunction

  task automatic pushExp(logic [1:0] t, logic [7:0] b);
    expQ.push_back({t, b});
  endtask

  task automatic buildApply(int m);
    pushExp(2'd0, 8'h36);
    for (int i = 0; i < 8; i++) begin
      pushExp(2'd1, offsetOf(i));
      pushExp(2'd2, tbl[m * 8 + i]);
    end
    pushExp(2'd0, 8'h16);
  endtask

  task automatic buildOtp(bit alt);
    logic [23:0] pg;
    int len;
    pg  = alt ? 24'h000200 : 24'h00021F;
    len = alt ? 528 : 784;
    pushExp(2'd0, 8'hFF); pushExp(2'd0, 8'h36); pushExp(2'd1, 8'h38);
    pushExp(2'd2, 8'h52); pushExp(2'd0, 8'h16);
    pushExp(2'd0, 8'h17); pushExp(2'd0, 8'h04); pushExp(2'd0, 8'h19);
    pushExp(2'd0, 8'h00); pushExp(2'd1, 8'h00); pushExp(2'd1, 8'h00);
    pushExp(2'd1, pg[7:0]); pushExp(2'd1, pg[15:8]); pushExp(2'd1, pg[23:16]);
    pushExp(2'd0, 8'h30);
    for (int i = 0; i < len; i++) pushExp(2'd3, 8'h00);
    pushExp(2'd0, 8'hFF); pushExp(2'd0, 8'h36); pushExp(2'd1, 8'h38);
    pushExp(2'd2, 8'h00); pushExp(2'd0, 8'h16);
    pushExp(2'd0, 8'h00);
    for (int i = 0; i < 5; i++) pushExp(2'd1, 8'h00);
    pushExp(2'd0, 8'h30);
  endtask

  task automatic clearRun();
    gotQ.delete(); expQ.delete(); gotStream.delete(); expStream.delete();
    doneCnt = 0; errCnt = 0;
  endtask

  task automatic compareBeats(string req, int n);
    int bad = -1;
    check(gotQ.size() == n, req, "beat count", gotQ.size(), n);
    for (int i = 0; i < n && i < gotQ.size(); i++)
      if (bad < 0 && gotQ[i] !== expQ[i]) bad = i;
    if (bad >= 0)
      check(0, req, $sformatf("beat %0d {type,byte}", bad), gotQ[bad], expQ[bad]);
    else
      check(1, req, "beat contents", 0, 0);
  endtask

  task automatic waitEnd(int limit);
    for (int i = 0; i < limit && (doneCnt + errCnt) == 0; i++) tick();
    repeat (8) tick();
  endtask

  task automatic waitBeats(int n);
    for (int i = 0; i < 20000 && gotQ.size() < n; i++) tick();
    repeat (3) tick();
  endtask

  task automatic runApply(int m, int errAt_, bit poke, string req);
    clearRun();
    if (m < 6) buildApply(m);
    errAt = errAt_;
    @(negedge clk); applyReq = 1'b1; modeSel = 3'(m);
    @(negedge clk); applyReq = 1'b0;
    if (poke) begin
      repeat (3) tick();
      @(negedge clk); otpReq = 1'b1;
      @(negedge clk); otpReq = 1'b0;
    end
    waitEnd(2000);
    errAt = -1;
    if (m >= 6) begin
      check(gotQ.size() == 0, req, "beats on rejected mode", gotQ.size(), 0);
      check(errCnt == 1, req, "err pulses on rejected mode", errCnt, 1);
      check(doneCnt == 0, req, "done on rejected mode", doneCnt, 0);
    end else if (errAt_ >= 0) begin
      compareBeats(req, errAt_ + 1);
      check(errCnt == 1 && doneCnt == 0, req, "abort err/done", errCnt * 10 + doneCnt, 10);
    end else begin
      compareBeats(req, expQ.size());
      check(doneCnt == 1 && errCnt == 0, req, "done/err pulses", doneCnt * 10 + errCnt, 10);
    end
  endtask

  task automatic verdict(bit ok);
    @(negedge clk); verdictValid = 1'b1; verdictOk = ok;
    @(negedge clk); verdictValid = 1'b0;
  endtask

  task automatic runOtp(bit v1, bit v2, string req);
    clearRun();
    buildOtp(1'b0);
    @(negedge clk); otpReq = 1'b1;
    @(negedge clk); otpReq = 1'b0;
    waitBeats(expQ.size());
    verdict(v1);
    if (!v1) begin
      buildOtp(1'b1);
      waitBeats(expQ.size());
      verdict(v2);
    end
    waitEnd(200);
    compareBeats(req, expQ.size());
    check(gotStream.size() == expStream.size(), "R6", "streamed byte count",
          gotStream.size(), expStream.size());
    begin
      int bad = -1;
      for (int i = 0; i < gotStream.size() && i < expStream.size(); i++)
        if (bad < 0 && gotStream[i] !== expStream[i]) bad = i;
      check(bad < 0, "R6", "streamed byte value", bad < 0 ? 0 : gotStream[bad],
            bad < 0 ? 0 : expStream[bad]);
    end
    if (v1 || v2)
      check(doneCnt == 1 && errCnt == 0, "R8", "done after good verdict", doneCnt * 10 + errCnt, 10);
    else
      check(doneCnt == 0 && errCnt == 1, "R8", "err after two bad verdicts", doneCnt * 10 + errCnt, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rstN = 1'b0; applyReq = 0; otpReq = 0; tblWe = 0; modeSel = 0;
    modeCount = 4'd6; tblAddr = 0; tblData = 0; verdictValid = 0; verdictOk = 0;
    busReady = 0; phyErr = 0; rdByte = 0;
    repeat (4) tick();
    // R11 reset state
    check(busValid == 0 && otpValid == 0, "R11", "valids in reset", busValid, 0);
    check(done == 0 && err == 0, "R11", "pulses in reset", done | err, 0);
    @(negedge clk); rstN = 1'b1;
    tick();
    check(busValid == 0 && done == 0 && err == 0, "R11", "after reset release", busValid, 0);

    // R3 table load with random contents
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      tbl[i] = 8'($urandom); tblWe = 1'b1; tblAddr = 6'(i); tblData = tbl[i];
    end
    @(negedge clk); tblWe = 1'b0;

    // Directed: no backpressure, first and last valid mode (R1 R2 R3)
    readyAlways = 1;
    runApply(0, -1, 0, "R1/R2/R3 mode0");
    runApply(5, -1, 0, "R3 last valid mode");
    readyAlways = 0;

    // Constrained random modes with random backpressure (R2 R3 R10)
    for (int k = 0; k < 6; k++) runApply(int'($urandom % 6), -1, 0, "R3 random mode");

    // Out-of-range modes (R4)
    runApply(6, -1, 0, "R4");
    runApply(7, -1, 0, "R4");

    // Request while busy is ignored (R10)
    runApply(2, -1, 1, "R10 busy");
    repeat (20) tick();
    check(gotQ.size() == expQ.size(), "R10", "no beats after ignored request", gotQ.size(), expQ.size());

    // PHY failure aborts (R9)
    runApply(3, 4, 0, "R9 abort");
    runApply(1, 0, 0, "R9 abort first");

    // OTP fetch: first layout decodes (R5 R6 R7)
    runOtp(1'b1, 1'b0, "R5/R6/R7 otp");
    // Fallback to second layout (R8)
    runOtp(1'b0, 1'b1, "R8 fallback");
    // Both layouts fail (R8)
    runOtp(1'b0, 1'b0, "R8 both bad");

    // PHY failure during the OTP unlock (R9)
    clearRun();
    errAt = 6;
    @(negedge clk); otpReq = 1'b1;
    @(negedge clk); otpReq = 1'b0;
    waitEnd(2000);
    errAt = -1;
    check(gotQ.size() == 7, "R9", "beats before otp abort", gotQ.size(), 7);
    check(errCnt == 1 && doneCnt == 0, "R9", "otp abort err", errCnt, 1);

    summary();
    $finish;
  end
endmodule